// File: doc/BRIEF.md
# Floating-Point Condition Code Predicate Unit

This block holds the four-bit condition state left by the last floating-point result or comparison. It answers 32 conditional predicates against that state for branch, set-on-condition, loop and trap decisions. An update strobe loads the state from a pre-classified result: a sign flag, zero, infinity and NaN flags, and for compares an unordered flag. A test strobe with a 5-bit predicate code returns true or false in the same cycle.

The predicates follow IEEE four-valued logic. The state can be equal, less, greater or unordered, so a predicate and its integer-style opposite can both be false. The low four bits of the code choose one of 16 Boolean functions. The top bit marks the predicate as IEEE-nonaware. A nonaware test that meets an unordered state raises a branch/set-on-unordered event. The event appears as a pulse next to the test and also collects into a sticky flag that software clears through a dedicated input.

Top module: `fpcc_predicate_unit`

## Requirements
- R1: After reset, cc_out is 4'b0000 and bsun_sticky is 0.
- R2: On a clock edge with upd_valid high, cc_out loads {NAN, I, Z, N} in bits 3..0. The fields are N = upd_sign, NAN = upd_nan | (upd_is_cmp & upd_unord), I = upd_inf & ~NAN, and Z = upd_zero & ~NAN & ~upd_inf.
- R3: With upd_valid low, cc_out keeps its value. A test in the same cycle as an update evaluates the value held before that update.
- R4: Relation flags are un = NAN, eq = Z & ~NAN, gt = ~N & ~Z & ~NAN and lt = N & ~Z & ~NAN. With test_valid high, test_result is the OR of the flags whose select bits are set in test_code[3:0], where bit 3 selects un, bit 2 selects lt, bit 1 selects gt and bit 0 selects eq.
- R5: test_code[4] has no effect on test_result.
- R6: test_result is 0 whenever test_valid is low.
- R7: bsun_pulse equals test_valid & test_code[4] & NAN in the same cycle. Codes with bit 4 clear never raise it.
- R8: bsun_sticky goes to 1 at the edge after a bsun_pulse. It goes to 0 at an edge where bsun_clear is high and no pulse is present. A pulse wins over a clear in the same cycle. Otherwise the sticky flag holds.
- R9: In the unordered state, GT (5'b10010) and LE (5'b10101) are false, NGT (5'b11101) is true, and all three raise bsun_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Load the condition state |
| upd_is_cmp | input | 1 | Update comes from a compare |
| upd_sign | input | 1 | Result is negative |
| upd_zero | input | 1 | Result is zero |
| upd_inf | input | 1 | Result is infinite |
| upd_nan | input | 1 | Result is NaN |
| upd_unord | input | 1 | Compare had a NaN operand |
| test_valid | input | 1 | Evaluate a predicate |
| test_code | input | 5 | Predicate code; bit 4 selects the nonaware group |
| bsun_clear | input | 1 | Clear the sticky unordered flag |
| cc_out | output | 4 | Condition state {NAN, I, Z, N} |
| test_result | output | 1 | Predicate outcome |
| bsun_pulse | output | 1 | Nonaware predicate met unordered state |
| bsun_sticky | output | 1 | Accumulated unordered event flag |

## Verification
The bench builds the unit with the default 5-bit predicate code, which is the only useful size here. At that size the sweep is complete: all 64 combinations of the six classification inputs are loaded, and each resulting state is tested against all 32 predicate codes. The expected outcomes come from the relation-mask formulation in the bench, not from the design's per-predicate equations. The sweep therefore reaches every ordered and unordered state, every aware and nonaware code, the update-versus-test ordering, and the clear-versus-pulse collision on the sticky flag.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int CC_W   = 4;
  localparam int CODE_W = 5;
  localparam int SEL_W  = CODE_W - 1;

  localparam int CC_N   = 0;
  localparam int CC_Z   = 1;
  localparam int CC_I   = 2;
  localparam int CC_NAN = 3;

  typedef logic [CC_W-1:0] cc_t;

  typedef enum logic [SEL_W-1:0] {
    P_F, P_EQ, P_OGT, P_OGE, P_OLT, P_OLE, P_OGL, P_OR,
    P_UN, P_UEQ, P_UGT, P_UGE, P_ULT, P_ULE, P_NE, P_T
  } pred_e;

  function automatic cc_t cc_encode(input logic sign, input logic zero,
                                    input logic inf, input logic nan,
                                    input logic is_cmp, input logic unord);
    cc_t  c;
    logic n_any;
    n_any     = nan | (is_cmp & unord);
    c[CC_N]   = sign;
    c[CC_NAN] = n_any;
    c[CC_I]   = inf & ~n_any;
    c[CC_Z]   = zero & ~n_any & ~inf;
    return c;
  endfunction

  function automatic logic pred_eval(input cc_t c, input logic [SEL_W-1:0] sel);
    logic n, z, u;
    logic r;
    n = c[CC_N];
    z = c[CC_Z];
    u = c[CC_NAN];
    case (pred_e'(sel))
      P_F:     r = 1'b0;
      P_EQ:    r = z;
      P_OGT:   r = ~u & ~z & ~n;
      P_OGE:   r = z | (~u & ~n);
      P_OLT:   r = n & ~u & ~z;
      P_OLE:   r = z | (n & ~u);
      P_OGL:   r = ~u & ~z;
      P_OR:    r = ~u;
      P_UN:    r = u;
      P_UEQ:   r = u | z;
      P_UGT:   r = u | (~n & ~z);
      P_UGE:   r = u | z | ~n;
      P_ULT:   r = u | (n & ~z);
      P_ULE:   r = u | z | n;
      P_NE:    r = ~z;
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fpcc_encode.sv
module fpcc_encode
  import fpcc_pkg::*;
(
  input  logic sign,
  input  logic zero,
  input  logic inf,
  input  logic nan,
  input  logic is_cmp,
  input  logic unord,
  output cc_t  next_cc
);
  always_comb next_cc = cc_encode(sign, zero, inf, nan, is_cmp, unord);
endmodule

// File: rtl/fpcc_state.sv
module fpcc_state
  import fpcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic nan_in,
  input  cc_t  d,
  output cc_t  q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R3
  AST_CC_NAN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (load && nan_in) |=> q[CC_NAN]); // R2
  AST_CC_Z_NAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(q[CC_Z] && q[CC_NAN])); // R2
endmodule

// File: rtl/fpcc_pred_eval.sv
module fpcc_pred_eval
  import fpcc_pkg::*;
#(
  parameter int CODE_W_P = CODE_W
) (
  input  cc_t               cc,
  input  logic              test_valid,
  input  logic [CODE_W_P-1:0] code,
  output logic              result,
  output logic              bsun_evt
);
  localparam int SEL_W_P = CODE_W_P - 1;

  logic nonaware;
  logic raw;

  assign nonaware = code[CODE_W_P-1];
  assign raw      = pred_eval(cc, code[SEL_W_P-1:0]);
  assign result   = test_valid & raw;
  assign bsun_evt = test_valid & nonaware & cc[CC_NAN];
endmodule

// File: rtl/fpcc_bsun_track.sv
module fpcc_bsun_track (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sticky <= 1'b0;
    else if (evt)  sticky <= 1'b1;
    else if (clr)  sticky <= 1'b0;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> sticky); // R8
  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && clr) |=> !sticky); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr) |=> $stable(sticky)); // R8
endmodule

// File: rtl/fpcc_predicate_unit.sv
module fpcc_predicate_unit
  import fpcc_pkg::*;
#(
  parameter int CODE_W_P = CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_valid,
  input  logic                upd_is_cmp,
  input  logic                upd_sign,
  input  logic                upd_zero,
  input  logic                upd_inf,
  input  logic                upd_nan,
  input  logic                upd_unord,
  input  logic                test_valid,
  input  logic [CODE_W_P-1:0] test_code,
  input  logic                bsun_clear,
  output logic [CC_W-1:0]     cc_out,
  output logic                test_result,
  output logic                bsun_pulse,
  output logic                bsun_sticky
);
  cc_t  next_cc;
  cc_t  cc_q;
  logic bsun_evt;

  fpcc_encode u_enc (
    .sign(upd_sign), .zero(upd_zero), .inf(upd_inf), .nan(upd_nan),
    .is_cmp(upd_is_cmp), .unord(upd_unord), .next_cc(next_cc)
  );

  fpcc_state u_state (
    .clk(clk), .rst_n(rst_n), .load(upd_valid),
    .nan_in(upd_nan), .d(next_cc), .q(cc_q)
  );

  fpcc_pred_eval #(.CODE_W_P(CODE_W_P)) u_eval (
    .cc(cc_q), .test_valid(test_valid), .code(test_code),
    .result(test_result), .bsun_evt(bsun_evt)
  );

  fpcc_bsun_track u_bsun (
    .clk(clk), .rst_n(rst_n), .evt(bsun_evt), .clr(bsun_clear),
    .sticky(bsun_sticky)
  );

  assign cc_out     = cc_q;
  assign bsun_pulse = bsun_evt;

  AST_IDLE_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    !test_valid |-> !test_result); // R6
  AST_AWARE_NO_BSUN: assert property (@(posedge clk) disable iff (!rst_n)
    (test_valid && !test_code[CODE_W_P-1]) |-> !bsun_pulse); // R7
  AST_UN_GT_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_valid && cc_out[CC_NAN] && test_code[CODE_W_P-2:0] == 4'b0010)
      |-> !test_result); // R9
  AST_UN_NGT_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_valid && cc_out[CC_NAN] && test_code[CODE_W_P-2:0] == 4'b1101)
      |-> test_result); // R9
endmodule

// File: tb/fpcc_predicate_unit_tb.sv
module fpcc_predicate_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0, upd_is_cmp = 1'b0, upd_sign = 1'b0;
  logic       upd_zero = 1'b0, upd_inf = 1'b0, upd_nan = 1'b0, upd_unord = 1'b0;
  logic       test_valid = 1'b0;
  logic [4:0] test_code = '0;
  logic       bsun_clear = 1'b0;
  logic [3:0] cc_out;
  logic       test_result, bsun_pulse, bsun_sticky;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m_cc = '0;
  logic       m_sticky = 1'b0;

  always #2.5 clk = ~clk;

  fpcc_predicate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_is_cmp(upd_is_cmp),
    .upd_sign(upd_sign), .upd_zero(upd_zero), .upd_inf(upd_inf),
    .upd_nan(upd_nan), .upd_unord(upd_unord), .test_valid(test_valid),
    .test_code(test_code), .bsun_clear(bsun_clear), .cc_out(cc_out),
    .test_result(test_result), .bsun_pulse(bsun_pulse), .bsun_sticky(bsun_sticky)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cc=%b code=%b", req, act, exp, m_cc, test_code);
    end
  endtask

  function automatic logic exp_res(input logic [3:0] c, input logic [4:0] code);
    logic un, eq, gt, lt;
    un = c[3];
    eq = c[1] & ~c[3];
    gt = ~c[0] & ~c[1] & ~c[3];
    lt = c[0] & ~c[1] & ~c[3];
    return |(code[3:0] & {un, lt, gt, eq});
  endfunction

  function automatic logic exp_pulse(input logic [3:0] c, input logic tv, input logic [4:0] code);
    return tv & code[4] & c[3];
  endfunction

  task automatic check_comb(input string rr, input string rb);
    #1;
    chk(rr, test_result, test_valid ? exp_res(m_cc, test_code) : 1'b0);
    chk(rb, bsun_pulse, exp_pulse(m_cc, test_valid, test_code));
  endtask

  task automatic step();
    logic pl, nan_e;
    pl = exp_pulse(m_cc, test_valid, test_code);
    if (pl) m_sticky = 1'b1;
    else if (bsun_clear) m_sticky = 1'b0;
    if (upd_valid) begin
      nan_e = upd_nan | (upd_is_cmp & upd_unord);
      m_cc = {nan_e, upd_inf & ~nan_e, upd_zero & ~nan_e & ~upd_inf, upd_sign};
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2_R3 cc", cc_out, m_cc);
    chk("R8 sticky", bsun_sticky, m_sticky);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cc reset", cc_out, 0);
    chk("R1 sticky reset", bsun_sticky, 0);

    for (int v = 0; v < 64; v++) begin
      {upd_is_cmp, upd_sign, upd_zero, upd_inf, upd_nan, upd_unord} = 6'(v);
      upd_valid  = 1'b1;
      test_valid = 1'b1;
      test_code  = 5'b11101;
      check_comb("R3 test sees old state", "R7 pulse old state");
      step();
      upd_valid = 1'b0;
      for (int c = 0; c < 32; c++) begin
        test_code = 5'(c);
        check_comb(c[4] ? "R5 R4 nonaware result" : "R4 aware result", "R7 pulse");
        step();
      end
      if (m_cc[3]) begin
        test_code = 5'b10010; #1; chk("R9 GT false", test_result, 0);
        test_code = 5'b10101; #1; chk("R9 LE false", test_result, 0);
        test_code = 5'b11101; #1; chk("R9 NGT true", test_result, 1);
        chk("R9 NGT bsun", bsun_pulse, 1);
        test_code  = 5'b10000;
        bsun_clear = 1'b1;
        step();
        chk("R8 pulse wins clear", bsun_sticky, 1);
      end
      test_valid = 1'b0;
      bsun_clear = 1'b1;
      test_code  = 5'b01111;
      check_comb("R6 idle result", "R7 idle pulse");
      step();
      bsun_clear = 1'b0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule